// File: doc/BRIEF.md
# Floating-Point Conditional Branch Resolver

This block settles the outcome of a floating-point conditional branch. It is handed the instruction word, the address of the branch, and the two-bit condition code left by the latest floating-point compare. From these it decides whether the branch is taken and computes the branch destination. It also reports two things to the fetch logic: where fetch should go after the branch, and whether the instruction in the delay slot must be squashed.

Each request arrives with a one-cycle valid strobe. All results are registered and appear one clock later, together with an output-valid pulse. The fetch unit, the pipeline and the compare logic that produces the condition code are outside this block. The block only turns a branch word and a condition code into a redirect decision.

Top module: `fpbr_resolver`

## Requirements
- R1: The condition code uses the encoding equal=0, less=1, greater=2, unordered=3. The condition selector is instruction bits 28:25. Selectors 0..7 take the branch on these outcomes: 0 on none, 1 on {less, greater, unordered}, 2 on {less, greater}, 3 on {less, unordered}, 4 on {less}, 5 on {greater, unordered}, 6 on {greater}, 7 on {unordered}.
- R2: Selectors 8..15 take the branch on these outcomes: 8 on all four, 9 on {equal}, 10 on {equal, unordered}, 11 on {equal, greater}, 12 on {equal, greater, unordered}, 13 on {equal, less}, 14 on {equal, less, unordered}, 15 on {equal, less, greater}.
- R3: `out_target` is the branch address plus four times the 22-bit displacement in bits 21:0. The displacement is sign-extended from bit 21, and the sum wraps modulo 2^32. The target is produced whether or not the branch is taken.
- R4: An untaken branch with the annul bit (instruction bit 29) clear gives taken=0, annul=0 and next_sel=0 (sequential: the slot runs, then fetch continues in line).
- R5: An untaken branch with the annul bit set gives taken=0, annul=1 and next_sel=0.
- R6: A taken branch with a selector other than 8 gives taken=1, annul=0 and next_sel=1 (the slot runs, then fetch goes to the target), whatever the annul bit.
- R7: Selector 8 with the annul bit set gives taken=1, annul=1 and next_sel=2 (the slot is squashed and fetch goes straight to the target). Selector 8 with the annul bit clear behaves as R6.
- R8: Results are registered. `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. When `in_valid` is low, the result outputs hold their previous values.
- R9: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_insn | input | 32 | Branch instruction word |
| in_pc | input | 32 | Address of the branch |
| in_fcc | input | 2 | Floating-point condition code |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_taken | output | 1 | Branch taken |
| out_target | output | 32 | Branch destination address |
| out_next_sel | output | 2 | 0 sequential, 1 target after slot, 2 target skipping slot |
| out_annul | output | 1 | Squash the delay-slot instruction |

## Verification
The bench sweeps every selector against every condition code, with the annul bit both clear and set. This catches a design that swaps two predicate rows or misreads the condition-code encoding: such a design takes or falls through on exactly the wrong combinations. The same sweep checks that annul is dropped for taken conditional branches and kept only for untaken ones and for branch-always. A design that annuls by the raw bit would squash useful slots. A design that skips the always-special case would run a slot that should vanish.

Displacement corners are also covered: the largest forward and backward offsets, and sums that wrap through address zero. A design with a wrong sign-extension width or a missing shift by two would land on the wrong target in these cases. Idle cycles are checked for a stray output-valid and for a target that changes when no request came in.

// File: rtl/fpbr_pkg.sv
package fpbr_pkg;

  typedef enum logic [1:0] {
    FCC_EQ = 2'd0,
    FCC_LT = 2'd1,
    FCC_GT = 2'd2,
    FCC_UN = 2'd3
  } fcc_e;

  typedef enum logic [1:0] {
    NXT_SEQ     = 2'd0,
    NXT_DELAYED = 2'd1,
    NXT_DIRECT  = 2'd2
  } nxt_sel_e;

  localparam int unsigned NUM_OUTCOMES = 4;
  localparam logic [3:0]  SEL_ALWAYS   = 4'd8;
  localparam logic [3:0]  SEL_NEVER    = 4'd0;

  // Outcome set per selector, bit k set when outcome code k takes the branch.
  // Bit order {UN, GT, LT, EQ}.
  function automatic logic [NUM_OUTCOMES-1:0] outcome_mask(input logic [3:0] sel);
    logic [NUM_OUTCOMES-1:0] m;
    case (sel)
      4'd0:    m = 4'b0000;
      4'd1:    m = 4'b1110;
      4'd2:    m = 4'b0110;
      4'd3:    m = 4'b1010;
      4'd4:    m = 4'b0010;
      4'd5:    m = 4'b1100;
      4'd6:    m = 4'b0100;
      4'd7:    m = 4'b1000;
      4'd8:    m = 4'b1111;
      4'd9:    m = 4'b0001;
      4'd10:   m = 4'b1001;
      4'd11:   m = 4'b0101;
      4'd12:   m = 4'b1101;
      4'd13:   m = 4'b0011;
      4'd14:   m = 4'b1011;
      default: m = 4'b0111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fpbr_cond_eval.sv
module fpbr_cond_eval
  import fpbr_pkg::*;
(
  input  logic [3:0] sel,
  input  logic [1:0] fcc,
  output logic       hit,
  output logic       is_always
);

  logic [NUM_OUTCOMES-1:0] fcc_onehot;
  logic [NUM_OUTCOMES-1:0] sel_mask;

  genvar k;
  generate
    for (k = 0; k < NUM_OUTCOMES; k++) begin : g_onehot
      assign fcc_onehot[k] = (fcc == k[1:0]);
    end
  endgenerate

  assign sel_mask  = outcome_mask(sel);
  assign hit       = |(fcc_onehot & sel_mask);
  assign is_always = (sel == SEL_ALWAYS);

  always_comb begin
    AST_ONEHOT_FCC: assert ($onehot0(fcc_onehot) && (fcc_onehot != '0)); // R1
    if (sel == SEL_NEVER)
      AST_NEVER_MISSES: assert (!hit); // R1
    if (is_always)
      AST_ALWAYS_HITS: assert (hit); // R2
  end

endmodule

// File: rtl/fpbr_target_calc.sv
module fpbr_target_calc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 22
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target
);

  localparam int unsigned EXT_W = ADDR_W - DISP_W - 2;

  logic [ADDR_W-1:0] byte_offset;

  assign byte_offset = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
  assign target      = pc + byte_offset;

  always_comb begin
    AST_WORD_ALIGNED_STEP: assert (target[1:0] == pc[1:0]); // R3
  end

endmodule

// File: rtl/fpbr_slot_ctl.sv
module fpbr_slot_ctl
  import fpbr_pkg::*;
(
  input  logic     hit,
  input  logic     is_always,
  input  logic     annul_bit,
  output logic     annul,
  output nxt_sel_e next_sel
);

  always_comb begin
    if (!hit) begin
      annul    = annul_bit;
      next_sel = NXT_SEQ;
    end else if (is_always && annul_bit) begin
      annul    = 1'b1;
      next_sel = NXT_DIRECT;
    end else begin
      annul    = 1'b0;
      next_sel = NXT_DELAYED;
    end
  end

endmodule

// File: rtl/fpbr_resolver.sv
module fpbr_resolver
  import fpbr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned INSN_W    = 32,
  parameter int unsigned DISP_W    = 22,
  parameter int unsigned SEL_LSB   = 25,
  parameter int unsigned ANNUL_POS = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [1:0]        in_fcc,
  output logic              out_valid,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_target,
  output logic [1:0]        out_next_sel,
  output logic              out_annul
);

  localparam int unsigned SEL_MSB = SEL_LSB + 3;

  logic [3:0]        sel;
  logic              hit;
  logic              is_always;
  logic              annul_c;
  nxt_sel_e          next_c;
  logic [ADDR_W-1:0] target_c;
  logic              unused_insn_bits;

  assign sel              = in_insn[SEL_MSB:SEL_LSB];
  assign unused_insn_bits = ^{in_insn[INSN_W-1:ANNUL_POS+1], in_insn[SEL_LSB-1:DISP_W]};

  fpbr_cond_eval u_cond (
    .sel       (sel),
    .fcc       (in_fcc),
    .hit       (hit),
    .is_always (is_always)
  );

  fpbr_target_calc #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) u_target (
    .pc     (in_pc),
    .disp   (in_insn[DISP_W-1:0]),
    .target (target_c)
  );

  fpbr_slot_ctl u_slot (
    .hit       (hit),
    .is_always (is_always),
    .annul_bit (in_insn[ANNUL_POS]),
    .annul     (annul_c),
    .next_sel  (next_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_taken    <= 1'b0;
      out_target   <= '0;
      out_next_sel <= NXT_SEQ;
      out_annul    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken    <= hit;
        out_target   <= target_c;
        out_next_sel <= next_c;
        out_annul    <= annul_c;
      end
    end
  end

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_target) && $stable(out_taken) && $stable(out_annul))); // R8
  AST_UNTAKEN_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_taken) |-> (out_next_sel == NXT_SEQ)); // R4
  AST_DIRECT_SQUASHES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_next_sel == NXT_DIRECT) |-> (out_annul && out_taken)); // R7
  AST_DELAYED_KEEPS_SLOT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_next_sel == NXT_DELAYED) |-> (!out_annul && out_taken)); // R6

endmodule

// File: tb/fpbr_resolver_bench.sv
module fpbr_resolver_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_insn;
  logic [31:0] in_pc;
  logic [1:0]  in_fcc;
  logic        out_valid;
  logic        out_taken;
  logic [31:0] out_target;
  logic [1:0]  out_next_sel;
  logic        out_annul;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpbr_resolver u_fpbr_resolver (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_insn      (in_insn),
    .in_pc        (in_pc),
    .in_fcc       (in_fcc),
    .out_valid    (out_valid),
    .out_taken    (out_taken),
    .out_target   (out_target),
    .out_next_sel (out_next_sel),
    .out_annul    (out_annul)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected predicate, built from the requirement lists (codes E=0 L=1 G=2 U=3).
  function automatic bit exp_take(input int sel, input int cc);
    bit e = (cc == 0);
    bit l = (cc == 1);
    bit g = (cc == 2);
    bit u = (cc == 3);
    case (sel)
      0:  return 1'b0;
      1:  return l | g | u;
      2:  return l | g;
      3:  return l | u;
      4:  return l;
      5:  return g | u;
      6:  return g;
      7:  return u;
      8:  return 1'b1;
      9:  return e;
      10: return e | u;
      11: return e | g;
      12: return e | g | u;
      13: return e | l;
      14: return e | l | u;
      default: return e | l | g;
    endcase
  endfunction

  function automatic logic [31:0] exp_target(input logic [31:0] pc, input logic [21:0] d);
    longint sd = d[21] ? longint'(d) - (longint'(1) << 22) : longint'(d);
    return 32'(longint'(pc) + sd * 4);
  endfunction

  // Issue one request at a falling edge, read the result at the next falling edge,
  // then confirm the idle cycle after it.
  task automatic run_one(input int sel, input int cc, input bit an,
                         input logic [21:0] d, input logic [31:0] pc);
    bit          tk;
    logic [31:0] tg;
    logic [1:0]  ns;
    bit          ea;
    tk = exp_take(sel, cc);
    tg = exp_target(pc, d);
    if (!tk)                        begin ns = 2'd0; ea = an;   end
    else if (sel == 8 && an)        begin ns = 2'd2; ea = 1'b1; end
    else                            begin ns = 2'd1; ea = 1'b0; end
    in_valid = 1'b1;
    in_insn  = {2'b01, an, 4'(sel), 3'b110, d};
    in_pc    = pc;
    in_fcc   = 2'(cc);
    @(negedge clk);
    in_valid = 1'b0;
    in_insn  = ~in_insn;
    in_pc    = ~pc;
    in_fcc   = ~in_fcc;
    check("R8 valid pulse", 64'(out_valid), 64'd1);
    check(sel < 8 ? "R1 taken" : "R2 taken", 64'(out_taken), 64'(tk));
    check("R3 target", 64'(out_target), 64'(tg));
    if (!tk && !an) begin
      check("R4 annul", 64'(out_annul), 64'(ea));
      check("R4 next_sel", 64'(out_next_sel), 64'(ns));
    end else if (!tk) begin
      check("R5 annul", 64'(out_annul), 64'(ea));
      check("R5 next_sel", 64'(out_next_sel), 64'(ns));
    end else if (sel == 8) begin
      check("R7 annul", 64'(out_annul), 64'(ea));
      check("R7 next_sel", 64'(out_next_sel), 64'(ns));
    end else begin
      check("R6 annul", 64'(out_annul), 64'(ea));
      check("R6 next_sel", 64'(out_next_sel), 64'(ns));
    end
    @(negedge clk);
    check("R8 idle no valid", 64'(out_valid), 64'd0);
    check("R8 idle hold target", 64'(out_target), 64'(tg));
    check("R8 idle hold taken", 64'(out_taken), 64'(tk));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst      = 1'b1;
    in_valid = 1'b1;
    in_insn  = 32'hFFFF_FFFF;
    in_pc    = 32'h1234_5678;
    in_fcc   = 2'd1;
    repeat (3) @(negedge clk);
    check("R9 reset valid", 64'(out_valid), 64'd0);
    check("R9 reset taken", 64'(out_taken), 64'd0);
    check("R9 reset target", 64'(out_target), 64'd0);
    check("R9 reset next_sel", 64'(out_next_sel), 64'd0);
    check("R9 reset annul", 64'(out_annul), 64'd0);
    rst      = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    // Full sweep: every selector, every condition code, annul clear and set.
    for (int sel = 0; sel < 16; sel++) begin
      for (int cc = 0; cc < 4; cc++) begin
        for (int an = 0; an < 2; an++) begin
          int idx = sel * 8 + cc * 2 + an;
          logic [21:0] d  = 22'(idx * 32'h1357B) ^ (idx[0] ? 22'h200000 : 22'h0);
          logic [31:0] pc = 32'h4000_0000 + 32'(idx) * 32'h44;
          run_one(sel, cc, bit'(an), d, pc);
        end
      end
    end

    // Displacement corners for R3.
    run_one(8, 0, 1'b0, 22'h1FFFFF, 32'h0000_1000);
    run_one(8, 0, 1'b0, 22'h200000, 32'h0100_0000);
    run_one(9, 0, 1'b1, 22'h000001, 32'hFFFF_FFFC);
    run_one(9, 1, 1'b0, 22'h3FFFFE, 32'h0000_0004);
    run_one(0, 3, 1'b1, 22'h000000, 32'h8000_0000);
    run_one(15, 3, 1'b1, 22'h3FFFFF, 32'h0000_0000);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule